// File: doc/BRIEF.md
# Checkpointed Return Address Stack

This block predicts the targets of subroutine returns in a speculative front end. A call pushes its return address and a return pops the newest one as the predicted target. The entries are kept as a doubly linked list over a small pool of storage slots, and an allocator hands out unused slots. When the stack runs out of room, the oldest live entry is reclaimed.

Before each unresolved branch, the branch logic takes a checkpoint. The checkpoint records the head, the tail, the depth, every link and the set of occupied slots. A slot that any live checkpoint still holds is never handed out again. If the branch later turns out to be mispredicted, a restore by checkpoint number brings the stack back exactly, including entries that were popped on the wrong path. A correctly resolved branch releases its checkpoint. A checkpoint taken in a cycle that also carries a call or a return records the stack after that operation.

Top module: `ras_ckpt`

## Requirements
- R1: After reset the stack is empty: a pop gives `pop_valid_o` low, `ck_avail_o` is high and `ck_id_o` is 0.
- R2: Pops return the pushed addresses in last-in, first-out order, with `pop_valid_o` high and `pop_addr_o` equal to the address, in the cycle the pop is presented.
- R3: A pop on an empty stack gives `pop_valid_o` low and changes nothing, so a later push followed by a pop returns that pushed address.
- R4: When push and pop are presented in the same cycle, the push is performed and the pop is dropped with `pop_valid_o` low.
- R5: The pool holds 16 entries. This count includes the entries held only by live checkpoints. A push when no slot is free reclaims the oldest live entry, so the newest 16 addresses stay available. If the live stack is empty and every slot is held by checkpoints, the push is dropped.
- R6: `ck_avail_o` is high while any of the 16 checkpoint slots is free. `ck_id_o` gives the lowest free slot number. A take when no slot is free is ignored. A take records the stack as it stands after that cycle's push or pop.
- R7: A restore makes the live stack exactly equal to the recorded one. Entries popped since the checkpoint come back in their order, and entries pushed since the checkpoint are gone.
- R8: A restore has priority over a push or pop in the same cycle. That push or pop is dropped, and `pop_valid_o` is low.
- R9: A restore frees the restored checkpoint slot. A restore naming a slot that holds no checkpoint leaves the stack unchanged.
- R10: A release frees the named checkpoint slot and leaves the live stack unchanged.
- R11: A slot held by a live checkpoint is not reused by later pushes, so the addresses seen after a restore are the original ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Call: push an address |
| push_addr_i | input | AW | Return address to push |
| pop_i | input | 1 | Return: pop the top entry |
| pop_valid_o | output | 1 | The pop was taken and `pop_addr_o` is a prediction |
| pop_addr_o | output | AW | Address at the top of the stack (0 when the stack is empty) |
| ck_take_i | input | 1 | Record a checkpoint in slot `ck_id_o` |
| ck_avail_o | output | 1 | A checkpoint slot is free |
| ck_id_o | output | log2(NCK) | Lowest free checkpoint slot |
| ck_release_i | input | 1 | Free a checkpoint slot |
| ck_release_id_i | input | log2(NCK) | Slot to free |
| restore_i | input | 1 | Roll the stack back to a checkpoint |
| restore_id_i | input | log2(NCK) | Slot to restore from |

## Verification
The property linking a push to the next cycle's pop assumes that a push is never dropped. A push is dropped only when the live stack is empty and every slot is held by checkpoints. The stimulus that exercises that case therefore puts an idle cycle between the dropped push and the next pop. The remaining properties assume only that inputs are valid, 2-state values once reset is released. The release and restore numbers the bench drives are either slots it has taken or slots it deliberately left empty to exercise R9.

// File: rtl/ras_ckpt.sv
module ras_ckpt #(
  parameter int DEPTH = 16,
  parameter int AW    = 64,
  parameter int NCK   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_i,
  input  logic [AW-1:0]          push_addr_i,
  input  logic                   pop_i,
  output logic                   pop_valid_o,
  output logic [AW-1:0]          pop_addr_o,
  input  logic                   ck_take_i,
  output logic                   ck_avail_o,
  output logic [$clog2(NCK)-1:0] ck_id_o,
  input  logic                   ck_release_i,
  input  logic [$clog2(NCK)-1:0] ck_release_id_i,
  input  logic                   restore_i,
  input  logic [$clog2(NCK)-1:0] restore_id_i
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(NCK);
  typedef logic [PW-1:0] ptr_t;

  logic [AW-1:0]    addr_q [DEPTH];
  ptr_t             prv_q [DEPTH], nxt_q [DEPTH], n_prv [DEPTH], n_nxt [DEPTH];
  ptr_t             head_q, tail_q, n_head, n_tail;
  logic [CW-1:0]    cnt_q, n_cnt;
  logic [DEPTH-1:0] live_q, n_live;

  ptr_t             ck_prv [NCK][DEPTH];
  ptr_t             ck_nxt [NCK][DEPTH];
  ptr_t             ck_head [NCK], ck_tail [NCK];
  logic [CW-1:0]    ck_cnt [NCK];
  logic [DEPTH-1:0] ck_mask [NCK];
  logic [NCK-1:0]   ck_vld;

  logic [DEPTH-1:0] held, free_v;
  ptr_t             fsel, victim;
  logic [IW-1:0]    take_id;
  logic             have_free, empty, do_push, do_pop, reclaim, take_ok, rs_hit;

  always_comb begin
    held = '0;
    for (int i = 0; i < NCK; i++)
      if (ck_vld[i]) held = held | ck_mask[i];
  end

  assign free_v    = ~(live_q | held);
  assign have_free = |free_v;

  always_comb begin
    fsel = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (free_v[i]) fsel = ptr_t'(i);
  end

  always_comb begin
    take_id = '0;
    for (int i = NCK - 1; i >= 0; i--)
      if (!ck_vld[i]) take_id = IW'(i);
  end

  assign empty       = (cnt_q == '0);
  assign do_push     = push_i & ~restore_i & (have_free | ~empty);
  assign do_pop      = pop_i & ~push_i & ~restore_i & ~empty;
  assign reclaim     = do_push & ~have_free;
  assign victim      = have_free ? fsel : tail_q;
  assign rs_hit      = restore_i & ck_vld[restore_id_i];
  assign ck_avail_o  = ~&ck_vld;
  assign ck_id_o     = take_id;
  assign take_ok     = ck_take_i & ck_avail_o;
  assign pop_valid_o = do_pop;
  assign pop_addr_o  = empty ? '0 : addr_q[head_q];

  always_comb begin
    n_prv  = prv_q;
    n_nxt  = nxt_q;
    n_head = head_q;
    n_tail = tail_q;
    n_cnt  = cnt_q;
    n_live = live_q;
    if (rs_hit) begin
      n_prv  = ck_prv[restore_id_i];
      n_nxt  = ck_nxt[restore_id_i];
      n_head = ck_head[restore_id_i];
      n_tail = ck_tail[restore_id_i];
      n_cnt  = ck_cnt[restore_id_i];
      n_live = ck_mask[restore_id_i];
    end else if (do_push) begin
      n_prv[victim] = head_q;
      if (!empty && !(reclaim && cnt_q == CW'(1))) n_nxt[head_q] = victim;
      n_head         = victim;
      n_live[victim] = 1'b1;
      if (empty) begin
        n_tail = victim;
        n_cnt  = CW'(1);
      end else if (reclaim) begin
        n_tail = (cnt_q == CW'(1)) ? victim : nxt_q[tail_q];
      end else begin
        n_cnt = cnt_q + 1'b1;
      end
    end else if (do_pop) begin
      n_live[head_q] = 1'b0;
      n_head         = prv_q[head_q];
      n_cnt          = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      live_q <= '0;
    end else begin
      head_q <= n_head;
      tail_q <= n_tail;
      cnt_q  <= n_cnt;
      live_q <= n_live;
    end
  end

  always_ff @(posedge clk) begin
    prv_q <= n_prv;
    nxt_q <= n_nxt;
    if (do_push) addr_q[victim] <= push_addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_vld <= '0;
    end else begin
      for (int i = 0; i < NCK; i++) begin
        if (take_ok && take_id == IW'(i))
          ck_vld[i] <= 1'b1;
        else if ((ck_release_i && ck_release_id_i == IW'(i)) ||
                 (restore_i && restore_id_i == IW'(i)))
          ck_vld[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCK; i++) begin
      if (take_ok && take_id == IW'(i)) begin
        ck_prv[i]  <= n_prv;
        ck_nxt[i]  <= n_nxt;
        ck_head[i] <= n_head;
        ck_tail[i] <= n_tail;
        ck_cnt[i]  <= n_cnt;
        ck_mask[i] <= n_live;
      end else if (reclaim && ck_vld[i] && ck_mask[i][victim]) begin
        ck_mask[i][victim] <= 1'b0;
        if (ck_tail[i] == victim) begin
          ck_tail[i] <= ck_nxt[i][victim];
          ck_cnt[i]  <= ck_cnt[i] - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ras_ckpt_chk.sv
module ras_ckpt_chk #(
  parameter int AW = 64,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic [AW-1:0] push_addr_i,
  input logic          pop_i,
  input logic          pop_valid_o,
  input logic [AW-1:0] pop_addr_o,
  input logic          ck_take_i,
  input logic          ck_avail_o,
  input logic [IW-1:0] ck_id_o,
  input logic          ck_release_i,
  input logic          restore_i
);
  p_pop_after_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !restore_i) |=> ((pop_i && !push_i && !restore_i) |->
      (pop_valid_o && pop_addr_o == $past(push_addr_i))));

  p_push_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !pop_valid_o);

  p_take_moves_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_take_i && ck_avail_o) |=> (!ck_avail_o || ck_id_o != $past(ck_id_o)));

  p_restore_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |-> !pop_valid_o);

  p_release_keeps_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_release_i && !push_i && !pop_i && !restore_i) |=> $stable(pop_addr_o));
endmodule

bind ras_ckpt ras_ckpt_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_addr_i(push_addr_i),
  .pop_i(pop_i), .pop_valid_o(pop_valid_o), .pop_addr_o(pop_addr_o),
  .ck_take_i(ck_take_i), .ck_avail_o(ck_avail_o), .ck_id_o(ck_id_o),
  .ck_release_i(ck_release_i), .restore_i(restore_i)
);

// File: tb/ras_ckpt_tb.sv
`timescale 1ns/1ps
module ras_ckpt_tb;
  localparam int DEPTH = 16;
  localparam int NCK   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0, pop_i = 1'b0, ck_take_i = 1'b0;
  logic        ck_release_i = 1'b0, restore_i = 1'b0;
  logic [63:0] push_addr_i = '0;
  logic [3:0]  ck_release_id_i = '0, restore_id_i = '0;
  logic        pop_valid_o, ck_avail_o;
  logic [63:0] pop_addr_o;
  logic [3:0]  ck_id_o;

  ras_ckpt u_dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_addr_i(push_addr_i),
    .pop_i(pop_i), .pop_valid_o(pop_valid_o), .pop_addr_o(pop_addr_o),
    .ck_take_i(ck_take_i), .ck_avail_o(ck_avail_o), .ck_id_o(ck_id_o),
    .ck_release_i(ck_release_i), .ck_release_id_i(ck_release_id_i),
    .restore_i(restore_i), .restore_id_i(restore_id_i)
  );

  always #4 clk = ~clk;

  typedef struct {
    bit          pv;
    logic [63:0] pa;
    bit          av;
    int          id;
    string       tag;
  } exp_t;

  exp_t        expq[$];
  int          nchk = 0, nfail = 0;
  bit          done = 0;

  int          live[$];
  int          ckq[NCK][$];
  bit          ckv[NCK];
  logic [63:0] taddr[int];
  int          ntok = 0;

  function automatic int held_count();
    bit seen[int];
    foreach (live[k]) seen[live[k]] = 1;
    for (int i = 0; i < NCK; i++)
      if (ckv[i]) foreach (ckq[i][k]) seen[ckq[i][k]] = 1;
    return seen.size();
  endfunction

  task automatic step(input bit push, input logic [63:0] a, input bit pop,
                      input bit take, input bit rel, input int relid,
                      input bit rs, input int rsid, input string tag);
    exp_t e;
    int   fid;
    bit   fav;
    @(posedge clk);
    #1;
    push_i = push; push_addr_i = a; pop_i = pop; ck_take_i = take;
    ck_release_i = rel; ck_release_id_i = relid[3:0];
    restore_i = rs; restore_id_i = rsid[3:0];
    fav = 0; fid = 0;
    for (int i = NCK - 1; i >= 0; i--) if (!ckv[i]) begin fav = 1; fid = i; end
    e.pv  = pop && !push && !rs && live.size() > 0;
    e.pa  = e.pv ? taddr[live[live.size()-1]] : '0;
    e.av  = fav;
    e.id  = fid;
    e.tag = tag;
    expq.push_back(e);
    if (rs) begin
      if (ckv[rsid]) live = ckq[rsid];
    end else if (push) begin
      if (held_count() < DEPTH) begin
        taddr[ntok] = a; live.push_back(ntok); ntok++;
      end else if (live.size() > 0) begin
        int v;
        v = live.pop_front();
        for (int i = 0; i < NCK; i++)
          for (int k = ckq[i].size() - 1; k >= 0; k--)
            if (ckq[i][k] == v) ckq[i].delete(k);
        taddr[ntok] = a; live.push_back(ntok); ntok++;
      end
    end else if (pop && live.size() > 0) begin
      void'(live.pop_back());
    end
    if (rel) ckv[relid] = 0;
    if (rs) ckv[rsid] = 0;
    if (take && fav) begin ckq[fid] = live; ckv[fid] = 1; end
  endtask

  task automatic do_push(input logic [63:0] a, input string tag);
    step(1, a, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic do_pop(input string tag);
    step(0, '0, 1, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic do_idle(input string tag);
    step(0, '0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #6;
      while (expq.size() > 0) begin
        exp_t e;
        bit   bad;
        e = expq.pop_front();
        nchk++;
        bad = (pop_valid_o !== e.pv) || (e.pv && pop_addr_o !== e.pa) ||
              (ck_avail_o !== e.av) || (e.av && int'(ck_id_o) != e.id);
        if (bad) begin
          nfail++;
          $display("FAIL %s: pop_valid=%0b exp %0b pop_addr=%h exp %h avail=%0b exp %0b id=%0d exp %0d",
                   e.tag, pop_valid_o, e.pv, pop_addr_o, e.pa, ck_avail_o, e.av, ck_id_o, e.id);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL timeout: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCK; i++) ckv[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    do_pop("R1 reset empty");
    // R2 lifo order
    do_push(64'hA000_0000_0000_0011, "R2 push");
    do_push(64'hA000_0000_0000_0022, "R2 push");
    do_push(64'hA000_0000_0000_0033, "R2 push");
    repeat (3) do_pop("R2 lifo pop");
    // R3 empty pop leaves state
    do_pop("R3 empty pop");
    do_push(64'hB000_0000_0000_0001, "R3 push after empty pop");
    do_pop("R3 pop after empty pop");
    do_pop("R3 empty again");
    // R4 push wins
    step(1, 64'hC000_0000_0000_00C1, 1, 0, 0, 0, 0, 0, "R4 push and pop");
    do_pop("R4 pushed value present");
    // R7 R8 R11 checkpoint and rollback
    do_push(64'hD000_0000_0000_00D1, "R7 push");
    do_push(64'hD000_0000_0000_00D2, "R7 push");
    step(0, '0, 0, 1, 0, 0, 0, 0, "R6 take slot 0");
    do_pop("R7 wrong-path pop");
    do_pop("R7 wrong-path pop");
    do_push(64'hE000_0000_0000_00E1, "R11 wrong-path push");
    do_push(64'hE000_0000_0000_00E2, "R11 wrong-path push");
    step(0, '0, 1, 0, 0, 0, 1, 0, "R8 restore with pop");
    do_pop("R7 restored top");
    do_pop("R11 restored second");
    do_pop("R7 empty after restore");
    // R9 restored slot freed
    step(0, '0, 0, 1, 0, 0, 0, 0, "R9 slot 0 free again");
    // R10 release
    do_push(64'hF000_0000_0000_00F1, "R10 push");
    step(0, '0, 0, 0, 1, 0, 0, 0, "R10 release slot 0");
    do_idle("R10 slot 0 free");
    do_pop("R10 stack untouched");
    // R9 restore from empty slot
    do_push(64'h1000_0000_0000_0001, "R9 push");
    step(1, 64'h1000_0000_0000_0002, 0, 0, 0, 0, 1, 5, "R9 restore unheld slot with push");
    do_pop("R9 stack unchanged");
    do_pop("R9 empty");
    // R6 fill all checkpoint slots
    do_push(64'h2000_0000_0000_0002, "R6 push");
    for (int i = 0; i < NCK; i++) step(0, '0, 0, 1, 0, 0, 0, 0, "R6 take");
    step(0, '0, 0, 1, 0, 0, 0, 0, "R6 take while full");
    do_idle("R6 no slot free");
    for (int i = 0; i < NCK; i++) step(0, '0, 0, 0, 1, i, 0, 0, "R10 release all");
    do_pop("R10 stack after releases");
    do_idle("R6 all free");
    // R5 overflow with no checkpoints
    for (int i = 0; i < 20; i++) do_push(64'h3000_0000_0000_0000 + 64'(i), "R5 fill");
    for (int i = 0; i < 17; i++) do_pop("R5 newest sixteen");
    // R5 dropped push when all slots held
    for (int i = 0; i < 16; i++) do_push(64'h4000_0000_0000_0000 + 64'(i), "R5 fill");
    step(0, '0, 0, 1, 0, 0, 0, 0, "R6 take full stack");
    for (int i = 0; i < 16; i++) do_pop("R5 drain");
    do_push(64'h5000_0000_0000_0005, "R5 push with every slot held");
    do_idle("R5 idle");
    do_pop("R5 push was dropped");
    step(0, '0, 0, 0, 0, 0, 1, 0, "R7 restore full stack");
    for (int i = 0; i < 16; i++) do_pop("R11 full restore pops");
    do_pop("R3 final empty");

    repeat (2) @(posedge clk);
    #7;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule